// File: doc/BRIEF.md
# Stream Packet Checker with Statistics Registers

This block sits at the receive end of a loopback or link test. It accepts packets on a stream slave port, which is always ready outside reset, and compares every beat with a pattern it regenerates locally. The pattern starts each packet from a fixed seed word and rotates that word left by one bit on every following beat. The block also checks that every byte lane is enabled and that the packet has exactly the fixed number of beats set by a parameter. Once the last beat of a packet is accepted, the packet is judged either good or errored, and one of two counters advances.

A small AXI4-Lite slave exposes three counters: a transmit count supplied by the companion generator, the good-packet count and the error count. The same slave holds a self-clearing control bit. Writing 1 to that bit soft-resets the checker, clears both of its counters, and drives a one-cycle reset pulse out to the generator. A nonzero error count right after the link comes up is expected, because fragments of packets can arrive before the link is stable.

Top module: `stream_pkt_checker`

## Requirements
- R1: `s_tready` is 1 in every cycle in which `rst_n` is high and `soft_rst_o` is low. It is 0 while `rst_n` is low and in the single cycle in which `soft_rst_o` is high.
- R2: Beat k of a packet (k counted from 0) must carry `SEED` rotated left by k mod `DATA_W` bits, with every `s_tkeep` bit set to 1. A beat that differs in any data bit or any keep bit makes the whole packet an error.
- R3: A packet is good only if its `s_tlast` beat is beat number `PKT_BEATS`-1. A packet that ends earlier or later is an error.
- R4: When a beat with `s_tlast` = 1 is accepted, exactly one of the two counters increments, and on no other cycle does either counter change (apart from soft reset). An error on any beat counts against the packet even if later beats match. The next packet is judged from a fresh pattern and a cleared error flag.
- R5: The registers are addressed by word index on `cfg_awaddr`/`cfg_araddr`. Index 0 returns `tx_count`, index 1 the good-packet count and index 2 the errored-packet count, zero-extended to 32 bits.
- R6: A read of index 3 returns 0 with response OKAY (2'b00). A read or write at any index above 3 gets response SLVERR (2'b10), and such a read returns data 0.
- R7: A write to index 3 with `cfg_wstrb[0]` = 1 and `cfg_wdata[0]` = 1 drives `soft_rst_o` high for exactly the one cycle after the write handshake edge. On the edge that ends that cycle, both counters clear, along with the pattern state and the error flag. A write of 0 has no effect.
- R8: A write is accepted on the edge where `cfg_awvalid` and `cfg_wvalid` are both high and no response is pending. `cfg_bvalid` rises in the next cycle and stays high until `cfg_bready`. A read is accepted on the edge where `cfg_arvalid` is high and no read data is pending. `cfg_rvalid` rises in the next cycle, and `cfg_rvalid` and `cfg_rdata` hold until `cfg_rready`.
- R9: Writes to indices 0 to 2 answer OKAY and change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | DATA_W | Stream data |
| s_tkeep | input | DATA_W/8 | Stream byte enables |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of packet |
| s_tready | output | 1 | Stream ready |
| tx_count | input | CNT_W | Transmit packet count from the generator |
| soft_rst_o | output | 1 | One-cycle soft reset pulse to the generator |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_awaddr | input | ADDR_W | Write register word index |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Write byte strobes |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_bresp | output | 2 | Write response code |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_araddr | input | ADDR_W | Read register word index |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response code |

## Verification
A stale error flag or a pattern register that does not return to the seed at a packet boundary shows up at the ports as a miscount. The fault appears on the very next good packet, which lands in the error counter, and a counter read after each packet exposes it within one packet. A beat index that stays off by one shows up the same way, because a correctly sized packet is then judged too short or too long. A soft reset that fails to clear any of this state is caught when a clean packet sent right after the pulse does not raise the good count by exactly one.

// File: rtl/spc_pkg.sv
// Package: shared constants and types for the stream packet checker.
// Assumes a 32-bit register bus addressed by word index.
package spc_pkg;

    localparam int REG_W = 32;
    localparam int STRB_W = REG_W / 8;
    localparam int NUM_REGS = 4;

    // Word indices of the register file; the order is what software relies on.
    localparam int IDX_TX   = 0;
    localparam int IDX_GOOD = 1;
    localparam int IDX_ERR  = 2;
    localparam int IDX_CTRL = 3;

    // Counter slots inside the counter bank.
    localparam int SLOT_GOOD = 0;
    localparam int SLOT_ERR  = 1;
    localparam int NUM_CNT   = 2;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_t;

endpackage

// File: rtl/spc_pattern.sv
// Module: spc_pattern
// Regenerates the expected word of each beat and tracks the beat index.
// The word starts at SEED and rotates left one bit per accepted beat. The
// index saturates at PKT_BEATS, which marks an overlong packet.
// Assumes clr_n already combines the hard and soft reset.
module spc_pattern #(
    parameter int              DATA_W    = 64,
    parameter int              PKT_BEATS = 4,
    parameter logic [DATA_W-1:0] SEED    = '1,
    parameter int              IDX_W     = $clog2(PKT_BEATS + 1)
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              beat_fire,
    input  logic              beat_last,
    output logic [DATA_W-1:0] exp_word,
    output logic [IDX_W-1:0]  beat_idx
);

    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(PKT_BEATS);

    // Advance the expected word and beat index per accepted beat.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            exp_word <= SEED;
            beat_idx <= '0;
        end else if (beat_fire) begin
            if (beat_last) begin
                exp_word <= SEED;
                beat_idx <= '0;
            end else begin
                exp_word <= {exp_word[DATA_W-2:0], exp_word[DATA_W-1]};
                if (beat_idx != IDX_SAT) begin
                    beat_idx <= beat_idx + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spc_verdict.sv
// Module: spc_verdict
// Compares each beat against the expected word and full keep, keeps a
// sticky error flag and issues a good/bad verdict on the last beat.
// Assumes beat_idx saturates at PKT_BEATS for overlong packets.
module spc_verdict #(
    parameter int DATA_W    = 64,
    parameter int PKT_BEATS = 4,
    parameter int IDX_W     = $clog2(PKT_BEATS + 1),
    localparam int KEEP_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              beat_fire,
    input  logic              beat_last,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [KEEP_W-1:0] beat_keep,
    input  logic [DATA_W-1:0] exp_word,
    input  logic [IDX_W-1:0]  beat_idx,
    output logic              pkt_done,
    output logic              pkt_good
);

    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PKT_BEATS - 1);
    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(PKT_BEATS);

    logic sticky_err;
    logic beat_bad;
    logic len_bad;

    // Flag a beat that breaks pattern, keep or length rules.
    always_comb begin
        len_bad  = (beat_idx == IDX_SAT) || (beat_last && (beat_idx != IDX_END));
        beat_bad = (beat_data != exp_word) || (beat_keep != {KEEP_W{1'b1}}) || len_bad;
    end

    // Accumulate beat errors until the packet closes.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            sticky_err <= 1'b0;
        end else if (beat_fire) begin
            sticky_err <= beat_last ? 1'b0 : (sticky_err | beat_bad);
        end
    end

    // Publish the verdict of the closing beat.
    always_comb begin
        pkt_done = beat_fire && beat_last;
        pkt_good = !(sticky_err || beat_bad);
    end

endmodule

// File: rtl/spc_counters.sv
// Module: spc_counters
// A bank of NUM identical wrapping event counters, cleared by clr_n.
// Assumes at most one increment request per slot per cycle.
module spc_counters #(
    parameter int CNT_W = 32,
    parameter int NUM   = 2
) (
    input  logic                       clk,
    input  logic                       clr_n,
    input  logic [NUM-1:0]             inc,
    output logic [NUM-1:0][CNT_W-1:0]  cnt_o
);

    logic [CNT_W-1:0] cnt_q [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        // Count one event per cycle on this slot.
        always_ff @(posedge clk) begin
            if (!clr_n) begin
                cnt_q[i] <= '0;
            end else if (inc[i]) begin
                cnt_q[i] <= cnt_q[i] + CNT_W'(1);
            end
        end
        assign cnt_o[i] = cnt_q[i];
    end

endmodule

// File: rtl/spc_regs.sv
// Module: spc_regs
// AXI4-Lite slave for the statistics registers and the soft-reset bit.
// Accepts a write when address and data are both valid and no response is
// pending; one read in flight. Only hard reset applies here, so a soft
// reset never cuts a transaction short.
module spc_regs #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      awvalid,
    output logic                      awready,
    input  logic [ADDR_W-1:0]         awaddr,
    input  logic                      wvalid,
    output logic                      wready,
    input  logic [spc_pkg::REG_W-1:0] wdata,
    input  logic [spc_pkg::STRB_W-1:0] wstrb,
    output logic                      bvalid,
    input  logic                      bready,
    output logic [1:0]                bresp,
    input  logic                      arvalid,
    output logic                      arready,
    input  logic [ADDR_W-1:0]         araddr,
    output logic                      rvalid,
    input  logic                      rready,
    output logic [spc_pkg::REG_W-1:0] rdata,
    output logic [1:0]                rresp,
    input  logic [CNT_W-1:0]          tx_count,
    input  logic [CNT_W-1:0]          good_count,
    input  logic [CNT_W-1:0]          err_count,
    output logic                      soft_rst
);
    import spc_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(NUM_REGS);

    logic wr_fire;
    logic rd_fire;
    logic ctrl_hit;
    logic [REG_W-1:0] rd_mux;
    logic unused_bits;

    assign unused_bits = ^{wdata[REG_W-1:1], wstrb[STRB_W-1:1]};

    // Handshake decode for both channels.
    always_comb begin
        wr_fire  = awvalid && wvalid && !bvalid;
        rd_fire  = arvalid && !rvalid;
        awready  = wr_fire;
        wready   = wr_fire;
        arready  = rd_fire;
        ctrl_hit = (awaddr == A_CTRL) && wstrb[0] && wdata[0];
    end

    // Select the register addressed by the read.
    always_comb begin
        case (araddr)
            ADDR_W'(IDX_TX):   rd_mux = REG_W'(tx_count);
            ADDR_W'(IDX_GOOD): rd_mux = REG_W'(good_count);
            ADDR_W'(IDX_ERR):  rd_mux = REG_W'(err_count);
            default:           rd_mux = '0;
        endcase
    end

    // Write response channel and self-clearing soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid   <= 1'b0;
            bresp    <= RESP_OKAY;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= 1'b0;
            if (wr_fire) begin
                bvalid   <= 1'b1;
                bresp    <= (awaddr < A_LIM) ? RESP_OKAY : RESP_SLVERR;
                soft_rst <= ctrl_hit;
            end else if (bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    // Read data channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            rresp  <= RESP_OKAY;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_mux;
            rresp  <= (araddr < A_LIM) ? RESP_OKAY : RESP_SLVERR;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/stream_pkt_checker.sv
// Module: stream_pkt_checker (top)
// Receives stream packets, checks each against a rotating-seed pattern and
// fixed length, counts good and errored packets, and exposes the counters
// plus a soft-reset bit over AXI4-Lite. Always ready outside reset.
module stream_pkt_checker #(
    parameter int                DATA_W    = 64,
    parameter int                PKT_BEATS = 4,
    parameter logic [DATA_W-1:0] SEED      = 64'h0123_4567_89AB_CDEF,
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 4,
    localparam int               KEEP_W    = DATA_W / 8,
    localparam int               IDX_W     = $clog2(PKT_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [KEEP_W-1:0] s_tkeep,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic [CNT_W-1:0]  tx_count,
    output logic              soft_rst_o,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [ADDR_W-1:0] cfg_awaddr,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_wstrb,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    output logic [1:0]        cfg_bresp,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    input  logic [ADDR_W-1:0] cfg_araddr,
    output logic              cfg_rvalid,
    input  logic              cfg_rready,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        cfg_rresp
);
    import spc_pkg::*;

    logic                       clr_n;
    logic                       beat_fire;
    logic [DATA_W-1:0]          exp_word;
    logic [IDX_W-1:0]           beat_idx;
    logic                       pkt_done;
    logic                       pkt_good;
    logic [NUM_CNT-1:0]         cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;
    logic [CNT_W-1:0]           good_cnt;
    logic [CNT_W-1:0]           err_cnt;

    // Combine resets, derive ready and per-packet counter requests.
    always_comb begin
        clr_n               = rst_n && !soft_rst_o;
        s_tready            = clr_n;
        beat_fire           = s_tvalid && s_tready;
        cnt_inc             = '0;
        cnt_inc[SLOT_GOOD]  = pkt_done && pkt_good;
        cnt_inc[SLOT_ERR]   = pkt_done && !pkt_good;
        good_cnt            = cnt_bus[SLOT_GOOD];
        err_cnt             = cnt_bus[SLOT_ERR];
    end

    spc_pattern #(
        .DATA_W(DATA_W), .PKT_BEATS(PKT_BEATS), .SEED(SEED), .IDX_W(IDX_W)
    ) u_pattern (
        .clk(clk), .clr_n(clr_n), .beat_fire(beat_fire), .beat_last(s_tlast),
        .exp_word(exp_word), .beat_idx(beat_idx)
    );

    spc_verdict #(
        .DATA_W(DATA_W), .PKT_BEATS(PKT_BEATS), .IDX_W(IDX_W)
    ) u_verdict (
        .clk(clk), .clr_n(clr_n), .beat_fire(beat_fire), .beat_last(s_tlast),
        .beat_data(s_tdata), .beat_keep(s_tkeep), .exp_word(exp_word),
        .beat_idx(beat_idx), .pkt_done(pkt_done), .pkt_good(pkt_good)
    );

    spc_counters #(
        .CNT_W(CNT_W), .NUM(NUM_CNT)
    ) u_counters (
        .clk(clk), .clr_n(clr_n), .inc(cnt_inc), .cnt_o(cnt_bus)
    );

    spc_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awvalid(cfg_awvalid), .awready(cfg_awready), .awaddr(cfg_awaddr),
        .wvalid(cfg_wvalid), .wready(cfg_wready), .wdata(cfg_wdata), .wstrb(cfg_wstrb),
        .bvalid(cfg_bvalid), .bready(cfg_bready), .bresp(cfg_bresp),
        .arvalid(cfg_arvalid), .arready(cfg_arready), .araddr(cfg_araddr),
        .rvalid(cfg_rvalid), .rready(cfg_rready), .rdata(cfg_rdata), .rresp(cfg_rresp),
        .tx_count(tx_count), .good_count(good_cnt), .err_count(err_cnt),
        .soft_rst(soft_rst_o)
    );

endmodule

// File: rtl/spc_checker.sv
// Module: spc_checker
// Protocol and counting properties for stream_pkt_checker, bound to the top.
module spc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic             s_tlast,
    input logic             soft_rst_o,
    input logic [CNT_W-1:0] good_cnt,
    input logic [CNT_W-1:0] err_cnt,
    input logic             cfg_bvalid,
    input logic             cfg_bready,
    input logic             cfg_rvalid,
    input logic             cfg_rready,
    input logic [31:0]      cfg_rdata
);

    // R1
    ready_outside_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == !soft_rst_o);

    // R4
    one_counter_per_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && s_tlast) |=>
        ((good_cnt == $past(good_cnt) + CNT_W'(1)) && (err_cnt == $past(err_cnt))) ||
        ((err_cnt == $past(err_cnt) + CNT_W'(1)) && (good_cnt == $past(good_cnt))));

    // R4
    counters_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(s_tvalid && s_tready && s_tlast) && !soft_rst_o) |=>
        ($stable(good_cnt) && $stable(err_cnt)));

    // R7
    soft_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R7
    soft_clears_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (good_cnt == '0) && (err_cnt == '0));

    // R8
    bresp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bvalid && !cfg_bready) |=> cfg_bvalid);

    // R8
    rdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && !cfg_rready) |=> (cfg_rvalid && $stable(cfg_rdata)));

endmodule

bind stream_pkt_checker spc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .soft_rst_o(soft_rst_o), .good_cnt(good_cnt),
    .err_cnt(err_cnt), .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
    .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready), .cfg_rdata(cfg_rdata)
);

// File: tb/stream_pkt_checker_tb.sv
// Bench: table of packet vectors walked by one loop, then directed tests.
module stream_pkt_checker_tb;

    localparam int DATA_W = 64;
    localparam int KEEP_W = DATA_W / 8;
    localparam int PKT_BEATS = 4;
    localparam logic [DATA_W-1:0] SEED = 64'h0123_4567_89AB_CDEF;
    localparam logic [31:0] TX_VAL = 32'hA5A5_0007;
    localparam int NONE = 255;

    // Each entry: {beats, corrupt-data beat, bad-keep beat, expect good}
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd4, 8'd255, 8'd255, 8'd1},
        {8'd4, 8'd2,   8'd255, 8'd0},
        {8'd4, 8'd255, 8'd0,   8'd0},
        {8'd3, 8'd255, 8'd255, 8'd0},
        {8'd5, 8'd255, 8'd255, 8'd0},
        {8'd4, 8'd255, 8'd255, 8'd1},
        {8'd4, 8'd0,   8'd255, 8'd0},
        {8'd4, 8'd255, 8'd3,   8'd0},
        {8'd1, 8'd255, 8'd255, 8'd0},
        {8'd4, 8'd255, 8'd255, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DATA_W-1:0] s_tdata = '0;
    logic [KEEP_W-1:0] s_tkeep = '0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic soft_rst_o;
    logic cfg_awvalid = 0, cfg_awready, cfg_wvalid = 0, cfg_wready;
    logic [3:0] cfg_awaddr = '0, cfg_araddr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic [3:0] cfg_wstrb = '0;
    logic cfg_bvalid, cfg_bready = 1'b1, cfg_arvalid = 0, cfg_arready;
    logic cfg_rvalid, cfg_rready = 1'b1;
    logic [1:0] cfg_bresp, cfg_rresp;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int exp_good = 0;
    int exp_err = 0;

    always #2 clk = ~clk;

    stream_pkt_checker u_dut (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .tx_count(TX_VAL), .soft_rst_o(soft_rst_o),
        .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready), .cfg_awaddr(cfg_awaddr),
        .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready), .cfg_wdata(cfg_wdata),
        .cfg_wstrb(cfg_wstrb), .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
        .cfg_bresp(cfg_bresp), .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready),
        .cfg_araddr(cfg_araddr), .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready),
        .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pattern_word(input int k);
        logic [DATA_W-1:0] w = SEED;
        for (int i = 0; i < (k % DATA_W); i++) w = {w[DATA_W-2:0], w[DATA_W-1]};
        return w;
    endfunction

    // Called right after a rising edge; returns right after a rising edge.
    task automatic send_pkt(input int nb, input int bad_d, input int bad_k);
        for (int b = 0; b < nb; b++) begin
            s_tvalid = 1'b1;
            s_tdata  = pattern_word(b) ^ ((b == bad_d) ? 64'h1 : 64'h0);
            s_tkeep  = (b == bad_k) ? {{(KEEP_W-1){1'b1}}, 1'b0} : {KEEP_W{1'b1}};
            s_tlast  = (b == nb - 1);
            @(posedge clk); #1;
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] addr, output logic [31:0] data,
                            output logic [1:0] resp);
        cfg_araddr  = addr;
        cfg_arvalid = 1'b1;
        @(posedge clk); #1;
        cfg_arvalid = 1'b0;
        check(cfg_rvalid == 1'b1, "R8", "rvalid after read", cfg_rvalid, 1);
        data = cfg_rdata;
        resp = cfg_rresp;
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic [3:0] addr, input logic [31:0] data,
                             output logic [1:0] resp, output logic soft_seen,
                             output logic rdy_seen);
        cfg_awaddr  = addr;
        cfg_wdata   = data;
        cfg_wstrb   = 4'hF;
        cfg_awvalid = 1'b1;
        cfg_wvalid  = 1'b1;
        @(posedge clk); #1;
        cfg_awvalid = 1'b0;
        cfg_wvalid  = 1'b0;
        check(cfg_bvalid == 1'b1, "R8", "bvalid after write", cfg_bvalid, 1);
        resp      = cfg_bresp;
        soft_seen = soft_rst_o;
        rdy_seen  = s_tready;
        @(posedge clk); #1;
    endtask

    task automatic check_counts(input string req);
        logic [31:0] d;
        logic [1:0] r;
        reg_read(4'd1, d, r);
        check(d == 32'(exp_good), req, "good count", d, exp_good);
        reg_read(4'd2, d, r);
        check(d == 32'(exp_err), req, "error count", d, exp_err);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [1:0] r;
        logic sft, rdy;

        repeat (3) @(posedge clk);
        #1;
        // R1: not ready while in reset
        check(s_tready == 1'b0, "R1", "tready in reset", s_tready, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(s_tready == 1'b1, "R1", "tready after reset", s_tready, 1);

        // R5: reset state and transmit count readback
        reg_read(4'd0, d, r);
        check(d == TX_VAL && r == 2'b00, "R5", "tx count", d, TX_VAL);
        check_counts("R5");

        // R2 R3 R4: table of packets
        for (int v = 0; v < NVEC; v++) begin
            send_pkt(int'(VEC[v][31:24]),
                     (VEC[v][23:16] == 8'hFF) ? NONE : int'(VEC[v][23:16]),
                     (VEC[v][15:8]  == 8'hFF) ? NONE : int'(VEC[v][15:8]));
            if (VEC[v][0]) exp_good++; else exp_err++;
            check_counts((VEC[v][31:24] != 8'd4) ? "R3" :
                         (VEC[v][0] ? "R4" : "R2"));
        end

        // R6: control reads as zero, out-of-range gets SLVERR
        reg_read(4'd3, d, r);
        check(d == 0 && r == 2'b00, "R6", "ctrl read", {d, 30'b0, r}, 0);
        reg_read(4'd6, d, r);
        check(r == 2'b10 && d == 0, "R6", "out-of-range read", {d, 30'b0, r}, 2);
        reg_write(4'd9, 32'h1, r, sft, rdy);
        check(r == 2'b10 && sft == 1'b0, "R6", "out-of-range write", {sft, r}, 2);

        // R9: writes to counters are ignored
        reg_write(4'd1, 32'hFFFF, r, sft, rdy);
        check(r == 2'b00, "R9", "counter write resp", r, 0);
        check_counts("R9");

        // R7: writing 0 to control has no effect
        reg_write(4'd3, 32'h0, r, sft, rdy);
        check(sft == 1'b0 && rdy == 1'b1, "R7", "write 0 no pulse", {sft, rdy}, 1);
        check_counts("R7");

        // R7 R1: soft reset mid-packet, then a clean packet counts good
        send_pkt(2, NONE, NONE);
        reg_write(4'd3, 32'h1, r, sft, rdy);
        check(sft == 1'b1, "R7", "soft pulse", sft, 1);
        check(rdy == 1'b0, "R1", "tready low in soft reset", rdy, 0);
        check(s_tready == 1'b1 && soft_rst_o == 1'b0, "R7", "pulse self-clears",
              {soft_rst_o, s_tready}, 1);
        exp_good = 0;
        exp_err  = 0;
        check_counts("R7");
        send_pkt(PKT_BEATS, NONE, NONE);
        exp_good = 1;
        check_counts("R7");

        // R4: error flag clears at packet end; error then good back to back
        send_pkt(PKT_BEATS, 1, NONE);
        send_pkt(PKT_BEATS, NONE, NONE);
        exp_err++;
        exp_good++;
        check_counts("R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule